// File: doc/BRIEF.md
# Encoded Integer ALU with Split Product Halves

This block is the combinational arithmetic and logic core of an integer execute stage. A 4-bit function field and a separate subtract bit together choose one of twelve operations on two operand words plus a shift amount. The block returns one result word and a flag that is high when that word is all zeros. Subtraction and both compares share one adder. The multiplier gives either half of the double-width unsigned product, depending on which of the two multiply codes is used.

Operand muxing, instruction decode and any multi-cycle multiply sequencing are left to the surrounding stage. The function field and the subtract bit come straight from the control path. Any pairing of the two that is not listed below is treated as undefined and produces a zero result.

Top module: `alu12_core`

## Requirements
- R1: With function 0000 and subtract bit 0, the result is opa plus opb, wrapped modulo 2^32.
- R2: With function 0000 and subtract bit 1, the result is opa minus opb, wrapped modulo 2^32. The adder forms it as opa plus the inverted opb with a carry-in of one.
- R3: With function 0001 and subtract bit 1, the result is 1 when opa is less than opb as two's-complement numbers and 0 otherwise. This also holds when the difference overflows.
- R4: With function 0010 and subtract bit 1, the result is 1 when opa is less than opb as unsigned numbers and 0 otherwise.
- R5: With subtract bit 0, function 0011 gives the bitwise AND of the operands, 0101 gives the bitwise OR, and 0100 gives the bitwise NOR.
- R6: With subtract bit 0, function 0110 shifts opb right by shamt and 0111 shifts opb left by shamt. Both shifts fill with zeros, and a shamt of 0 passes opb through unchanged.
- R7: With function 1000 and subtract bit 0, bits 31:16 of the result take opb[15:0] and bits 15:0 are zero.
- R8: With subtract bit 0, function 1001 gives bits 31:0 of the unsigned 64-bit product opa*opb and 1010 gives bits 63:32.
- R9: The zero output is 1 exactly when the result is all zeros, for every code.
- R10: Every other pairing of function and subtract bit gives a result of 0 and a zero output of 1. This covers 0001/0, 0010/0, 0011/1 to 1010/1, and all of 1011 to 1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_code | input | 4 | Operation field |
| sub_bit | input | 1 | Subtract qualifier, part of the operation code |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand; also the shifted value and the immediate source |
| shamt | input | 5 | Shift distance |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The signed compare is driven with operand pairs whose difference overflows, for example 0x7FFFFFFF against -1 and 0x80000000 against 1. A design that looked only at the sign bit of the difference would give the wrong answer on these. The unsigned compare is run on the same pairs, so a swapped carry sense shows up as a flipped bit. The multiply codes use all-ones operands, where a signed high half would differ from the unsigned 0xFFFFFFFE. Shifts are run at distances 0 and 31. Every unlisted code is swept, which catches a decoder that ignores the subtract bit and lets it alias onto a real operation. Addition is checked wrapping to zero, which catches a zero flag taken from the wrong signal.

// File: rtl/alu12_pkg.sv
package alu12_pkg;

   // Operation field values; the subtract bit qualifies each of them.
   localparam logic [3:0] FN_ADDSUB = 4'h0;
   localparam logic [3:0] FN_SLT    = 4'h1;
   localparam logic [3:0] FN_SLTU   = 4'h2;
   localparam logic [3:0] FN_AND    = 4'h3;
   localparam logic [3:0] FN_NOR    = 4'h4;
   localparam logic [3:0] FN_OR     = 4'h5;
   localparam logic [3:0] FN_SRL    = 4'h6;
   localparam logic [3:0] FN_SLL    = 4'h7;
   localparam logic [3:0] FN_LUI    = 4'h8;
   localparam logic [3:0] FN_MULLO  = 4'h9;
   localparam logic [3:0] FN_MULHI  = 4'hA;

   // Internal one-of-thirteen selection after decode.
   typedef enum logic [3:0] {
      SEL_ADD, SEL_SUB, SEL_SLT, SEL_SLTU, SEL_AND, SEL_NOR, SEL_OR,
      SEL_SRL, SEL_SLL, SEL_LUI, SEL_MLO, SEL_MHI, SEL_NONE
   } alu_sel_e;

   // Pairs the operation field with the subtract bit; anything unlisted is SEL_NONE.
   function automatic alu_sel_e decode_op(input logic [3:0] fn, input logic sub);
      alu_sel_e s;
      s = SEL_NONE;
      case (fn)
         FN_ADDSUB: s = sub ? SEL_SUB : SEL_ADD;
         FN_SLT:    if (sub)  s = SEL_SLT;
         FN_SLTU:   if (sub)  s = SEL_SLTU;
         FN_AND:    if (!sub) s = SEL_AND;
         FN_NOR:    if (!sub) s = SEL_NOR;
         FN_OR:     if (!sub) s = SEL_OR;
         FN_SRL:    if (!sub) s = SEL_SRL;
         FN_SLL:    if (!sub) s = SEL_SLL;
         FN_LUI:    if (!sub) s = SEL_LUI;
         FN_MULLO:  if (!sub) s = SEL_MLO;
         FN_MULHI:  if (!sub) s = SEL_MHI;
         default:   s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/alu12_addsub.sv
module alu12_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   output logic [DATA_W-1:0] sum,
   output logic              carry,
   output logic              ovf
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   full;

   // Subtraction reuses the adder: a + ~b + 1.
   assign b_eff = sub ? ~b : b;
   assign full  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
   assign sum   = full[DATA_W-1:0];
   assign carry = full[DATA_W];
   // Signed overflow: both addends agree in sign, the sum does not.
   assign ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/alu12_shifter.sv
module alu12_shifter #(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = 5,
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic [DATA_W-1:0]  val,
   input  logic [SHAMT_W-1:0] amt,
   output logic [DATA_W-1:0]  shl,
   output logic [DATA_W-1:0]  shr
);
   generate
      if (LOG_STAGES) begin : g_log
         // One stage per bit of the distance, each moving by a power of two.
         logic [DATA_W-1:0] lft [0:SHAMT_W];
         logic [DATA_W-1:0] rgt [0:SHAMT_W];
         assign lft[0] = val;
         assign rgt[0] = val;
         for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
            localparam int STEP = 1 << i;
            assign lft[i+1] = amt[i] ? {lft[i][DATA_W-1-STEP:0], {STEP{1'b0}}} : lft[i];
            assign rgt[i+1] = amt[i] ? {{STEP{1'b0}}, rgt[i][DATA_W-1:STEP]} : rgt[i];
         end
         assign shl = lft[SHAMT_W];
         assign shr = rgt[SHAMT_W];
      end else begin : g_op
         assign shl = val << amt;
         assign shr = val >> amt;
      end
   endgenerate
endmodule

// File: rtl/alu12_mul.sv
module alu12_mul #(
   parameter int DATA_W = 32,
   parameter bit ROW_ARRAY = 1'b0
) (
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   output logic [2*DATA_W-1:0] prod
);
   localparam int PW = 2 * DATA_W;

   generate
      if (ROW_ARRAY) begin : g_rows
         // Explicit shift-and-add rows, one per multiplier bit.
         logic [PW-1:0] acc [0:DATA_W];
         assign acc[0] = '0;
         for (genvar r = 0; r < DATA_W; r++) begin : g_row
            logic [PW-1:0] part;
            assign part     = b[r] ? ({{DATA_W{1'b0}}, a} << r) : '0;
            assign acc[r+1] = acc[r] + part;
         end
         assign prod = acc[DATA_W];
      end else begin : g_op
         assign prod = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
      end
   endgenerate
endmodule

// File: rtl/alu12_core.sv
module alu12_core
   import alu12_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int SHAMT_W    = $clog2(DATA_W),
   parameter bit LOG_SHIFT  = 1'b1,
   parameter bit MUL_ROWS   = 1'b0
) (
   input  logic [3:0]         fn_code,
   input  logic               sub_bit,
   input  logic [DATA_W-1:0]  opa,
   input  logic [DATA_W-1:0]  opb,
   input  logic [SHAMT_W-1:0] shamt,
   output logic [DATA_W-1:0]  result,
   output logic               zero
);
   localparam int HALF = DATA_W / 2;

   // Elaboration-time parameter checks.
   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("alu12_core: DATA_W must be even and at least 4");
      end
      if ((1 << SHAMT_W) != DATA_W) begin : g_bad_shamt
         $error("alu12_core: SHAMT_W must equal log2(DATA_W) with DATA_W a power of two");
      end
   endgenerate

   alu_sel_e          sel;
   logic [DATA_W-1:0] sum;
   logic              carry;
   logic              ovf;
   logic [DATA_W-1:0] shl;
   logic [DATA_W-1:0] shr;
   logic [2*DATA_W-1:0] prod;
   logic              lt_signed;
   logic              lt_unsigned;

   assign sel = decode_op(fn_code, sub_bit);

   // One adder serves add, subtract and both compares; sub_bit is its carry-in.
   alu12_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a     (opa),
      .b     (opb),
      .sub   (sub_bit),
      .sum   (sum),
      .carry (carry),
      .ovf   (ovf)
   );

   alu12_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .LOG_STAGES(LOG_SHIFT)) u_shift (
      .val (opb),
      .amt (shamt),
      .shl (shl),
      .shr (shr)
   );

   alu12_mul #(.DATA_W(DATA_W), .ROW_ARRAY(MUL_ROWS)) u_mul (
      .a    (opa),
      .b    (opb),
      .prod (prod)
   );

   // Signed: sign of difference corrected by overflow. Unsigned: borrow = no carry.
   assign lt_signed   = sum[DATA_W-1] ^ ovf;
   assign lt_unsigned = ~carry;

   always_comb begin
      result = '0;
      case (sel)
         SEL_ADD, SEL_SUB: result = sum;
         SEL_SLT:          result = {{(DATA_W-1){1'b0}}, lt_signed};
         SEL_SLTU:         result = {{(DATA_W-1){1'b0}}, lt_unsigned};
         SEL_AND:          result = opa & opb;
         SEL_NOR:          result = ~(opa | opb);
         SEL_OR:           result = opa | opb;
         SEL_SRL:          result = shr;
         SEL_SLL:          result = shl;
         SEL_LUI:          result = {opb[HALF-1:0], {HALF{1'b0}}};
         SEL_MLO:          result = prod[DATA_W-1:0];
         SEL_MHI:          result = prod[2*DATA_W-1:DATA_W];
         default:          result = '0;
      endcase
   end

   assign zero = ~|result;
endmodule

// File: rtl/alu12_checker.sv
module alu12_checker #(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = 5
) (
   input logic [3:0]         fn_code,
   input logic               sub_bit,
   input logic [DATA_W-1:0]  opa,
   input logic [DATA_W-1:0]  opb,
   input logic [SHAMT_W-1:0] shamt,
   input logic [DATA_W-1:0]  result,
   input logic               zero
);
   localparam int HALF = DATA_W / 2;

   logic code_known;
   always_comb begin
      code_known = (fn_code == 4'h0) ||
                   (sub_bit  && (fn_code == 4'h1 || fn_code == 4'h2)) ||
                   (!sub_bit && fn_code >= 4'h3 && fn_code <= 4'hA);
   end

   always_comb begin
      if (fn_code == 4'h0 && !sub_bit)
         assert_add_inverse_R1: assert ((result - opb) == opa)
            else $error("add result does not invert back to opa");
      if (fn_code == 4'h0 && sub_bit)
         assert_sub_inverse_R2: assert ((result + opb) == opa)
            else $error("subtract result does not invert back to opa");
      if (sub_bit && (fn_code == 4'h1 || fn_code == 4'h2))
         assert_cmp_single_bit_R3: assert (result[DATA_W-1:1] == '0)
            else $error("compare result has upper bits set");
      if (!sub_bit && (fn_code == 4'h6 || fn_code == 4'h7) && shamt == '0)
         assert_shift_zero_pass_R6: assert (result == opb)
            else $error("zero-distance shift altered the value");
      if (!sub_bit && fn_code == 4'h8)
         assert_upper_imm_R7: assert (result == {opb[HALF-1:0], {HALF{1'b0}}})
            else $error("upper-immediate placement wrong");
      if (!code_known)
         assert_unused_quiet_R10: assert (result == '0 && zero)
            else $error("unlisted code produced a nonzero result");
   end
endmodule

bind alu12_core alu12_checker #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_alu12_chk (
   .fn_code (fn_code),
   .sub_bit (sub_bit),
   .opa     (opa),
   .opb     (opb),
   .shamt   (shamt),
   .result  (result),
   .zero    (zero)
);

// File: tb/alu12_core_test.sv
module alu12_core_test;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   fn_code = '0;
   logic         sub_bit = 1'b0;
   logic [W-1:0] opa = '0;
   logic [W-1:0] opb = '0;
   logic [4:0]   shamt = '0;
   logic [W-1:0] result;
   logic         zero;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   alu12_core uut (
      .fn_code (fn_code),
      .sub_bit (sub_bit),
      .opa     (opa),
      .opb     (opb),
      .shamt   (shamt),
      .result  (result),
      .zero    (zero)
   );

   // Behavioural reference written from the requirements.
   function automatic logic [W-1:0] model(input logic [3:0] f, input logic s,
                                          input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic [4:0] sh);
      longint unsigned p;
      p = longint'(a) * longint'(b);
      case ({f, s})
         5'b0000_0: return a + b;
         5'b0000_1: return a - b;
         5'b0001_1: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         5'b0010_1: return (a < b) ? 32'd1 : 32'd0;
         5'b0011_0: return a & b;
         5'b0100_0: return ~(a | b);
         5'b0101_0: return a | b;
         5'b0110_0: return b >> sh;
         5'b0111_0: return b << sh;
         5'b1000_0: return {b[15:0], 16'h0000};
         5'b1001_0: return p[31:0];
         5'b1010_0: return p[63:32];
         default:   return '0;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] f, input logic s);
      case ({f, s})
         5'b0000_0: return "R1";
         5'b0000_1: return "R2";
         5'b0001_1: return "R3";
         5'b0010_1: return "R4";
         5'b0011_0, 5'b0100_0, 5'b0101_0: return "R5";
         5'b0110_0, 5'b0111_0: return "R6";
         5'b1000_0: return "R7";
         5'b1001_0, 5'b1010_0: return "R8";
         default:   return "R10";
      endcase
   endfunction

   task automatic compare(input string tag);
      logic [W-1:0] exp;
      exp = model(fn_code, sub_bit, opa, opb, shamt);
      checks++;
      if (result !== exp) begin
         fails++;
         $display("FAIL %s fn=%h sub=%0b a=%h b=%h sh=%0d: result=%h expected=%h",
                  tag, fn_code, sub_bit, opa, opb, shamt, result, exp);
      end
      checks++;
      if (zero !== (exp == '0)) begin
         fails++;
         $display("FAIL R9 zero flag fn=%h sub=%0b: zero=%0b expected=%0b",
                  fn_code, sub_bit, zero, (exp == '0));
      end
   endtask

   task automatic run(input logic [3:0] f, input logic s, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic [4:0] sh);
      @(posedge clk);
      #1;
      fn_code = f; sub_bit = s; opa = a; opb = b; shamt = sh;
      @(negedge clk);
      compare(tag_of(f, s));
   endtask

   initial begin
      // Reset state: all-zero inputs are an add of zeros (R1), zero flag high (R9).
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare("R1 reset");
      rst_n = 1'b1;

      // R1: add, including wrap to zero
      run(4'h0, 1'b0, 32'h0000_0005, 32'h0000_0007, 5'd0);
      run(4'h0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0);
      // R2: subtract, borrow through
      run(4'h0, 1'b1, 32'h0000_0003, 32'h0000_0005, 5'd0);
      run(4'h0, 1'b1, 32'h1234_5678, 32'h1234_5678, 5'd0);
      // R3: signed compare with overflowing differences
      run(4'h1, 1'b1, 32'h8000_0000, 32'h0000_0001, 5'd0);
      run(4'h1, 1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
      run(4'h1, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 5'd0);
      run(4'h1, 1'b1, 32'h0000_0004, 32'h0000_0004, 5'd0);
      // R4: unsigned compare on the same pairs
      run(4'h2, 1'b1, 32'h8000_0000, 32'h0000_0001, 5'd0);
      run(4'h2, 1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
      run(4'h2, 1'b1, 32'h0000_0004, 32'h0000_0004, 5'd0);
      // R5: bitwise
      run(4'h3, 1'b0, 32'hF0F0_AAAA, 32'hFF00_5555, 5'd0);
      run(4'h4, 1'b0, 32'h0000_0000, 32'h0000_0000, 5'd0);
      run(4'h4, 1'b0, 32'hF0F0_0000, 32'h0F0F_FFFF, 5'd0);
      run(4'h5, 1'b0, 32'hF000_0001, 32'h0F00_0010, 5'd0);
      // R6: shifts at distances 0, 1, 31
      run(4'h6, 1'b0, 32'h0, 32'h8000_0001, 5'd0);
      run(4'h6, 1'b0, 32'h0, 32'h8000_0001, 5'd31);
      run(4'h7, 1'b0, 32'h0, 32'h8000_0001, 5'd1);
      run(4'h7, 1'b0, 32'h0, 32'h0000_0003, 5'd31);
      // R7: upper immediate
      run(4'h8, 1'b0, 32'hDEAD_0000, 32'h1234_BEEF, 5'd0);
      // R8: both product halves, all-ones operands
      run(4'h9, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0);
      run(4'hA, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0);
      run(4'hA, 1'b0, 32'h0001_0000, 32'h0001_0000, 5'd0);
      // R10: sweep every code with nonzero operands
      for (int c = 0; c < 32; c++)
         run(c[4:1], c[0], 32'hA5A5_5A5A, 32'h3C3C_C3C3, 5'd7);
      // Mixed pseudo-random stimulus across all codes
      for (int n = 0; n < 800; n++)
         run(4'($urandom()), 1'($urandom()), $urandom(), $urandom(), 5'($urandom()));

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end
endmodule